// File: doc/BRIEF.md
# Serial Stimulus Timing Sequencer

This block drives a device under test from a small set of stored test vectors. Each vector is a partial truth-table entry. It holds a data word, its bit length and a 16-bit switch-control word. A write port fills the vector store. A start pulse then selects one entry and replays it.

A replay pulses the clear lines and shifts the switch-control word out on its own serial data and clock lines. A downstream serial-to-parallel stage turns that word into parallel switch settings. The block then shifts the data word into the device, fires a one-cycle load strobe and signals completion with a one-cycle done pulse.

A programmable half-period sets the rate of both shift clocks. Serial data changes only where the shift clock falls, so it is stable when the clock rises.

Top module: `stim_seq_top`

## Requirements
- R1: While reset is held and in the first cycle after it, busy, done, both clear lines, both shift clocks, both serial data lines and the load strobe are all low.
- R2: A write with wr_en high stores word, length and switch word at wr_addr on the clock edge. A later start with sel equal to that address replays exactly that entry.
- R3: Each replay runs in this order: both clear lines high together for 2H cycles, then the switch stream, then the data stream, then the load strobe, then done for one cycle. The word is sent in this order: switch word first, then data word.
- R4: The switch stream sends all 16 bits of the switch word, most significant bit first, one bit per rising edge of sw_sclk. Nothing appears on the data lines while it runs.
- R5: The data stream sends the low L bits of the data word, bit L-1 first, one bit per rising edge of dut_sclk. A length field of 0 or above 64 means L = 64.
- R6: Every shift clock period is H cycles low followed by H cycles high, where H is half_div sampled at start and a value of 0 counts as 1. Serial data holds steady while its clock is high.
- R7: Counting the first cycle after the start edge as cycle 0, done is high in cycle 2H(17+L)+1. busy stays high from cycle 0 through that cycle.
- R8: A start while busy is high is ignored. The running sequence keeps its timing, and no further clear pulse follows its done.
- R9: A write during a replay, even to the entry being replayed, does not change the bits sent by that replay. The next replay of that entry uses the new contents.
- R10: dut_set is high for exactly one cycle, in the cycle just before done. It is never high together with a clear line or a shift clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Vector store write enable |
| wr_addr | input | 3 | Vector store write address |
| wr_word | input | 64 | Data word to store |
| wr_len | input | 7 | Data bit length to store (0 or >64 means 64) |
| wr_sw | input | 16 | Switch-control word to store |
| start | input | 1 | Begin replay of entry sel (ignored while busy) |
| sel | input | 3 | Entry to replay |
| half_div | input | 8 | Shift clock half period in cycles (0 means 1) |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| dut_clr | output | 1 | Device clear strobe |
| dut_set | output | 1 | Device load strobe |
| dut_sclk | output | 1 | Device shift clock |
| dut_sdata | output | 1 | Device serial data |
| sw_clr | output | 1 | Switch stage clear |
| sw_sclk | output | 1 | Switch stage shift clock |
| sw_sdata | output | 1 | Switch stage serial data |

## Verification
Two events can land during a running replay and must stay apart from it:
- a rewrite of the very entry being shifted out;
- a second start pulse.

The bench rewrites the active entry partway through a replay. It then checks that every bit seen at a rising shift clock edge still matches the snapshot taken at start. A second replay of the same entry must carry the new contents. In another run, start is pulsed in the middle of the data stream. The done cycle must land exactly where the formula for the first start places it, and no clear pulse may follow.

// File: rtl/stim_pkg.sv
package stim_pkg;
  localparam int unsigned WORD_W = 64;
  localparam int unsigned LEN_W  = 7;
  localparam int unsigned SW_W   = 16;
  localparam int unsigned HALF_W = 8;

  typedef struct packed {
    logic [WORD_W-1:0] word;
    logic [LEN_W-1:0]  len;
    logic [SW_W-1:0]   sw;
  } vec_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CLR, ST_SWSH, ST_DSH, ST_SET, ST_DONE
  } st_t;

  // Length field to effective bit count: 0 or oversize selects the full word.
  function automatic logic [LEN_W-1:0] eff_len(input logic [LEN_W-1:0] l);
    if (l == '0 || l > LEN_W'(WORD_W)) return LEN_W'(WORD_W);
    return l;
  endfunction

  // Half-period field to effective cycle count: never below one.
  function automatic logic [HALF_W-1:0] eff_half(input logic [HALF_W-1:0] h);
    return (h == '0) ? HALF_W'(1) : h;
  endfunction

  // Move bit len-1 of the word to the top so shifting left sends it first.
  function automatic logic [WORD_W-1:0] align_top(input logic [WORD_W-1:0] w,
                                                  input logic [LEN_W-1:0] len);
    logic [LEN_W-1:0] sh;
    sh = LEN_W'(WORD_W) - len;
    return w << sh;
  endfunction
endpackage

// File: rtl/stim_vec_mem.sv
module stim_vec_mem
  import stim_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  vec_t          wdata,
  input  logic [AW-1:0] raddr,
  output vec_t          rdata
);
  vec_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/stim_tick_gen.sv
module stim_tick_gen #(
  parameter int unsigned HW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [HW-1:0] half,
  output logic          tick
);
  logic [HW-1:0] cnt;

  assign tick = run && (cnt == half - HW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                   cnt <= cnt + HW'(1);
  end

  // R6: the counter never runs past the programmed half period
  a_r6_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> cnt < half);
endmodule

// File: rtl/stim_shreg.sv
module stim_shreg #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         shift,
  output logic         msb
);
  logic [W-1:0] q;

  always_ff @(posedge clk) begin
    if (!rst_n)     q <= '0;
    else if (load)  q <= din;
    else if (shift) q <= {q[W-2:0], 1'b0};
  end

  assign msb = q[W-1];
endmodule

// File: rtl/stim_seq_top.sv
module stim_seq_top
  import stim_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [WORD_W-1:0] wr_word,
  input  logic [LEN_W-1:0]  wr_len,
  input  logic [SW_W-1:0]   wr_sw,
  input  logic              start,
  input  logic [AW-1:0]     sel,
  input  logic [HALF_W-1:0] half_div,
  output logic              busy,
  output logic              done,
  output logic              dut_clr,
  output logic              dut_set,
  output logic              dut_sclk,
  output logic              dut_sdata,
  output logic              sw_clr,
  output logic              sw_sclk,
  output logic              sw_sdata
);
  st_t               st;
  logic              phase;
  logic [LEN_W-1:0]  bitcnt, len_q;
  logic [HALF_W-1:0] half_q;
  vec_t              rd, wr_vec;
  logic              tick, sw_msb, d_msb;

  // Named internal events
  logic accept, run, rise_ev, fall_ev, sw_last, d_last;
  assign accept  = start && (st == ST_IDLE);
  assign run     = (st == ST_CLR) || (st == ST_SWSH) || (st == ST_DSH);
  assign rise_ev = tick && !phase;
  assign fall_ev = tick && phase;
  assign sw_last = (st == ST_SWSH) && fall_ev && (bitcnt == LEN_W'(SW_W - 1));
  assign d_last  = (st == ST_DSH) && fall_ev && (bitcnt == len_q - LEN_W'(1));

  assign wr_vec = '{word: wr_word, len: wr_len, sw: wr_sw};

  stim_vec_mem #(.DEPTH(DEPTH), .AW(AW)) mem_i (
    .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(wr_vec),
    .raddr(sel), .rdata(rd)
  );

  stim_tick_gen #(.HW(HALF_W)) tick_i (
    .clk(clk), .rst_n(rst_n), .run(run), .half(half_q), .tick(tick)
  );

  stim_shreg #(.W(SW_W)) sw_sr_i (
    .clk(clk), .rst_n(rst_n), .load(accept), .din(rd.sw),
    .shift(fall_ev && st == ST_SWSH), .msb(sw_msb)
  );

  stim_shreg #(.W(WORD_W)) d_sr_i (
    .clk(clk), .rst_n(rst_n), .load(accept),
    .din(align_top(rd.word, eff_len(rd.len))),
    .shift(fall_ev && st == ST_DSH), .msb(d_msb)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      phase  <= 1'b0;
      bitcnt <= '0;
      len_q  <= '0;
      half_q <= HALF_W'(1);
    end else begin
      unique case (st)
        ST_IDLE: if (accept) begin
          st     <= ST_CLR;
          phase  <= 1'b0;
          bitcnt <= '0;
          len_q  <= eff_len(rd.len);
          half_q <= eff_half(half_div);
        end
        ST_CLR: begin
          if (rise_ev) phase <= 1'b1;
          if (fall_ev) begin
            phase <= 1'b0;
            st    <= ST_SWSH;
          end
        end
        ST_SWSH: begin
          if (rise_ev) phase <= 1'b1;
          if (fall_ev) begin
            phase <= 1'b0;
            if (sw_last) begin
              bitcnt <= '0;
              st     <= ST_DSH;
            end else bitcnt <= bitcnt + LEN_W'(1);
          end
        end
        ST_DSH: begin
          if (rise_ev) phase <= 1'b1;
          if (fall_ev) begin
            phase <= 1'b0;
            if (d_last) begin
              bitcnt <= '0;
              st     <= ST_SET;
            end else bitcnt <= bitcnt + LEN_W'(1);
          end
        end
        ST_SET:  st <= ST_DONE;
        ST_DONE: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (st != ST_IDLE);
  assign done      = (st == ST_DONE);
  assign dut_clr   = (st == ST_CLR);
  assign sw_clr    = (st == ST_CLR);
  assign dut_set   = (st == ST_SET);
  assign sw_sclk   = (st == ST_SWSH) && phase;
  assign sw_sdata  = (st == ST_SWSH) && sw_msb;
  assign dut_sclk  = (st == ST_DSH) && phase;
  assign dut_sdata = (st == ST_DSH) && d_msb;

  // R6: serial data holds while its shift clock is high
  a_r6_data_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
    (dut_sclk && $past(dut_sclk)) |-> $stable(dut_sdata));
  a_r6_sw_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_sclk && $past(sw_sclk)) |-> $stable(sw_sdata));
  // R10: load strobe is followed directly by done and lasts one cycle
  a_r10_set_then_done: assert property (@(posedge clk) disable iff (!rst_n)
    dut_set |=> (done && !dut_set));
  // R3: done is a single-cycle pulse that ends the busy period
  a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));
  // R3: the clear pulse hands over to the switch stream
  a_r3_clr_to_switch: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dut_clr) |-> (st == ST_SWSH));
  // R8: an active sequence is never dropped before its done cycle
  a_r8_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);
endmodule

// File: tb/stim_seq_top_tb_top.sv
module stim_seq_top_tb_top;
  import stim_pkg::*;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        rst_n, wr_en, start;
  logic [2:0]  wr_addr, sel;
  logic [63:0] wr_word;
  logic [6:0]  wr_len;
  logic [15:0] wr_sw;
  logic [7:0]  half_div;
  logic busy, done, dut_clr, dut_set, dut_sclk, dut_sdata, sw_clr, sw_sclk, sw_sdata;

  stim_seq_top dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_word(wr_word),
    .wr_len(wr_len), .wr_sw(wr_sw), .start(start), .sel(sel), .half_div(half_div),
    .busy(busy), .done(done), .dut_clr(dut_clr), .dut_set(dut_set),
    .dut_sclk(dut_sclk), .dut_sdata(dut_sdata), .sw_clr(sw_clr),
    .sw_sclk(sw_sclk), .sw_sdata(sw_sdata)
  );

  int checks = 0;
  int errors = 0;
  bit exp_sw[$];
  bit exp_d[$];
  logic p_dsclk = 1'b0, p_swsclk = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Monitor: pop the scoreboard on every rising shift clock edge (R4, R5)
  always @(negedge clk) begin
    bit e;
    if (rst_n) begin
      if (sw_sclk && !p_swsclk) begin
        if (exp_sw.size() == 0) chk(1'b0, "R4", "unexpected switch bit", sw_sdata, 0);
        else begin
          e = exp_sw.pop_front();
          chk(sw_sdata === e, "R4", "switch bit", sw_sdata, e);
        end
        chk(dut_sclk == 1'b0 && dut_sdata == 1'b0, "R4", "data lines idle", dut_sclk, 0);
      end
      if (dut_sclk && !p_dsclk) begin
        if (exp_d.size() == 0) chk(1'b0, "R5", "unexpected data bit", dut_sdata, 0);
        else begin
          e = exp_d.pop_front();
          chk(dut_sdata === e, "R5", "data bit", dut_sdata, e);
        end
      end
      if (dut_set) chk(!dut_clr && !sw_clr && !dut_sclk && !sw_sclk, "R10",
                       "set overlaps clear or clock", 1, 0);
    end
    p_swsclk = sw_sclk;
    p_dsclk  = dut_sclk;
  end

  task automatic write_vec(input int a, input logic [63:0] w, input int len,
                           input logic [15:0] sw);
    wr_addr = 3'(a); wr_word = w; wr_len = 7'(len); wr_sw = sw; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Driver: push expected bits, start, follow the sequence to done.
  task automatic run_vec(input int idx, input logic [63:0] w, input int len,
                         input logic [15:0] sw, input int h, input bit poke_start,
                         input bit poke_write);
    int el, eh, k, clr_cnt, set_k, exp_k;
    el = (len == 0 || len > 64) ? 64 : len;
    eh = (h == 0) ? 1 : h;
    for (int i = 15; i >= 0; i--) exp_sw.push_back(sw[i]);
    for (int i = el - 1; i >= 0; i--) exp_d.push_back(w[i]);
    exp_k = 2 * eh * (17 + el) + 1;
    sel = 3'(idx); half_div = 8'(h); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    k = 0; clr_cnt = 0; set_k = -1;
    while (!done && k < 20000) begin
      if (dut_clr && sw_clr) clr_cnt++;
      if (dut_set) set_k = k;
      chk(busy, "R7", "busy during run", busy, 1);
      if (poke_start && k == 40) start = 1'b1;        // R8 stimulus
      if (poke_start && k == 41) start = 1'b0;
      if (poke_write && k == 50) begin                 // R9 stimulus
        wr_addr = 3'(idx); wr_word = ~w; wr_len = 7'd1; wr_sw = ~sw; wr_en = 1'b1;
      end
      if (poke_write && k == 51) wr_en = 1'b0;
      @(negedge clk);
      k++;
    end
    chk(k == exp_k, "R7", "done cycle", k, exp_k);
    chk(clr_cnt == 2 * eh, "R3", "clear length", clr_cnt, 2 * eh);
    chk(set_k == k - 1, "R10", "set cycle", set_k, k - 1);
    chk(exp_sw.size() == 0, "R4", "switch bits left", exp_sw.size(), 0);
    chk(exp_d.size() == 0, "R5", "data bits left", exp_d.size(), 0);
    exp_sw.delete(); exp_d.delete();
    @(negedge clk);
    chk(!done && !busy, "R3", "done one cycle", done, 0);
    for (int i = 0; i < 6; i++) begin
      chk(!dut_clr && !busy, "R8", "no restart after done", dut_clr, 0);
      @(negedge clk);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; start = 1'b0; wr_addr = '0; sel = '0;
    wr_word = '0; wr_len = '0; wr_sw = '0; half_div = 8'd1;
    repeat (3) @(negedge clk);
    chk({busy, done, dut_clr, dut_set, dut_sclk, dut_sdata, sw_clr, sw_sclk, sw_sdata} == '0,
        "R1", "outputs in reset", 1, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({busy, done, dut_clr, dut_set, dut_sclk, dut_sdata, sw_clr, sw_sclk, sw_sdata} == '0,
        "R1", "outputs after reset", 1, 0);

    // R2: load several entries, replay them out of order
    write_vec(0, 64'h0000_0000_0000_00A5, 8, 16'h8001);
    write_vec(1, 64'hDEAD_BEEF_1234_5678, 64, 16'h5A3C);
    write_vec(2, 64'hF0F0_0FF0_3C3C_A55A, 0, 16'hFFFF);
    write_vec(3, 64'h0123_4567_89AB_CDEF, 70, 16'h0000);
    write_vec(7, 64'hFFFF_FFFF_FFFF_FFFE, 1, 16'h1234);

    run_vec(1, 64'hDEAD_BEEF_1234_5678, 64, 16'h5A3C, 3, 0, 0);  // R2 R6 full word
    run_vec(0, 64'h0000_0000_0000_00A5, 8, 16'h8001, 1, 0, 0);   // R5 short word
    run_vec(2, 64'hF0F0_0FF0_3C3C_A55A, 0, 16'hFFFF, 0, 1, 0);   // R5 len 0, R6 h 0, R8
    run_vec(3, 64'h0123_4567_89AB_CDEF, 70, 16'h0000, 2, 0, 1);  // R5 oversize, R9 write
    run_vec(3, ~64'h0123_4567_89AB_CDEF, 1, ~16'h0000, 2, 0, 0); // R9 new contents
    run_vec(7, 64'hFFFF_FFFF_FFFF_FFFE, 1, 16'h1234, 2, 0, 0);   // R5 single bit

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule